// File: doc/BRIEF.md
# Auto-Reload Up-Counter with Update Qualification

This block is the counting core of a periodic timer. It advances a 16-bit count by one on every cycle where the prescaler supplies a tick. When the count equals the active reload limit, the next tick returns it to zero. That same tick produces an overflow pulse and, when allowed, an update event. The prescaler, the register decoding and any trigger or slave control sit outside the block. Software reaches the block through level control inputs, one-cycle write strobes and a one-cycle software update strobe.

The reload limit is kept as two registers: a staging copy, which takes every write, and an active copy, which the comparator uses. When staging is off, a write reaches the active copy straight away. When staging is on, the active copy is refreshed only on an update event, so a new period starts cleanly on a boundary. Two separate bits qualify the update path:
- An inhibit bit suppresses update events and the refresh of the active limit.
- A source-select bit keeps the software strobe from requesting the status flag.

A one-shot mode drops the run bit at the first update event. All event outputs are registered single-cycle pulses. Each pulse is high in the cycle where the count already shows its new value.

Top module: `reload_upcounter`

## Requirements
- R1: While counting is enabled and the active limit is nonzero, each cycle with `tick_i` high raises the count by one. A tick with the count equal to the active limit sets it to 0 instead, and `ovf_o` is high for exactly the one cycle in which the count first reads 0. Cycles without a tick leave the count unchanged.
- R2: With `preload_en_i` low, a reload write is seen on `reload_active_o` in the cycle after the write strobe.
- R3: With `preload_en_i` high, a reload write leaves `reload_active_o` unchanged. The written value moves to `reload_active_o` at the next update event.
- R4: With `upd_dis_i` high, an overflow still wraps the count and pulses `ovf_o`, but raises neither `update_o` nor `flag_req_o`.
- R5: A one-cycle `sw_upd_i` clears the count to 0 and pulses `psc_restart_o`. It pulses `update_o` only when `upd_dis_i` is low. With `upd_dis_i` high, the active reload value keeps its old contents.
- R6: With `req_src_i` high, a software update pulses `update_o` but not `flag_req_o`, while an overflow with `upd_dis_i` low pulses both.
- R7: With `one_shot_i` high, an update event clears `run_o` in the same cycle that `update_o` is high. After that the count does not advance on further ticks.
- R8: After software sets the run bit (`en_wr_i` with `en_val_i` high), a tick in the first cycle after the write is not counted. Ticks from the second cycle on are counted.
- R9: While the active reload value is 0, ticks leave the count unchanged and no overflow occurs.
- R10: After reset the count is 0, `run_o` is 0, `reload_active_o` is 0xFFFF and every event output is 0.
- R11: A software update in the same cycle as an overflow produces a single one-cycle `update_o` pulse, and the count reads 0 afterwards.
- R12: A counter write (`cnt_wr_i`) in a cycle with a counted tick loads `cnt_wdata_i` and the increment is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Count tick from the prescaler |
| en_wr_i | input | 1 | Write strobe for the run bit |
| en_val_i | input | 1 | Value written to the run bit |
| preload_en_i | input | 1 | 1: reload writes are staged until an update event |
| upd_dis_i | input | 1 | 1: update events are inhibited |
| req_src_i | input | 1 | 1: only overflow requests the flag |
| one_shot_i | input | 1 | 1: the run bit clears at the next update event |
| sw_upd_i | input | 1 | Software update strobe, one cycle |
| cnt_wr_i | input | 1 | Counter write strobe |
| cnt_wdata_i | input | CNT_W | Counter write data |
| rld_wr_i | input | 1 | Reload write strobe |
| rld_wdata_i | input | CNT_W | Reload write data |
| count_o | output | CNT_W | Current count |
| update_o | output | 1 | Update event pulse |
| ovf_o | output | 1 | Overflow pulse |
| flag_req_o | output | 1 | Request to set the update status flag |
| psc_restart_o | output | 1 | Request to clear the external prescaler counter |
| run_o | output | 1 | Current run bit |
| reload_active_o | output | CNT_W | Active reload value used for wrapping |

## Verification
The bench targets the corners where the qualification bits interact, and each one shows up at the ports if the design gets it wrong:
- Staged reload: a design that loads the staged limit on every write would show the new limit before any update event.
- Update inhibit: a design that ignores the inhibit bit would pulse `update_o` or the flag on overflow.
- Inhibited software update: a design that ignores the inhibit bit would change the active limit when a software update arrives.
- Source select: a design that ignores it would request the flag from a software update.
- One-shot stop: a design whose counter enable lags the auto-clear would let one more tick through after the stop.
- Zero limit: a design that misses the zero check would count past it.
- Overflow plus strobe: a design that does not merge them would emit two update pulses.
- Write priority: a design that favours the increment would read back the written value plus one.

// File: rtl/reload_upcounter_pkg.sv
package reload_upcounter_pkg;

    typedef struct packed {
        logic preload_en;
        logic upd_dis;
        logic req_src;
        logic one_shot;
    } ucnt_cfg_t;

    typedef struct packed {
        logic upd;
        logic ovf;
        logic flag;
        logic restart;
    } ucnt_evt_t;

    localparam ucnt_evt_t EVT_NONE = '{upd: 1'b0, ovf: 1'b0, flag: 1'b0, restart: 1'b0};

    function automatic logic limit_hit(input logic [63:0] cnt, input logic [63:0] lim);
        return (lim != 64'd0) && (cnt == lim);
    endfunction

endpackage

// File: rtl/ucnt_enable.sv
module ucnt_enable
    import reload_upcounter_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      en_wr,
    input  logic      en_val,
    input  ucnt_cfg_t cfg,
    input  logic      upd_now,
    output logic      run,
    output logic      cnt_en
);

    logic run_q;
    logic cnt_en_q;
    logic auto_stop;

    assign auto_stop = cfg.one_shot && upd_now;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= 1'b0;
        end else if (auto_stop) begin
            run_q <= 1'b0;
        end else if (en_wr) begin
            run_q <= en_val;
        end
    end

    // Counting follows the run bit one cycle late; an automatic stop is immediate.
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_en_q <= 1'b0;
        end else begin
            cnt_en_q <= run_q && !auto_stop;
        end
    end

    assign run    = run_q;
    assign cnt_en = cnt_en_q;

    AST_ONE_SHOT_STOP: assert property (@(posedge clk) disable iff (rst)
        (cfg.one_shot && upd_now) |=> (!run_q && !cnt_en_q)); // R7

    AST_ENABLE_LAG: assert property (@(posedge clk) disable iff (rst)
        (!run_q && en_wr && en_val && !auto_stop) |=> (run_q && !cnt_en_q)); // R8

endmodule

// File: rtl/ucnt_reload.sv
module ucnt_reload
    import reload_upcounter_pkg::*;
#(
    parameter int               CNT_W      = 16,
    parameter logic [CNT_W-1:0] RELOAD_RST = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  ucnt_cfg_t        cfg,
    input  logic             rld_wr,
    input  logic [CNT_W-1:0] rld_wdata,
    input  logic             upd_now,
    output logic [CNT_W-1:0] active
);

    logic [CNT_W-1:0] stage_q;
    logic [CNT_W-1:0] active_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= RELOAD_RST;
        end else if (rld_wr) begin
            stage_q <= rld_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= RELOAD_RST;
        end else if (!cfg.preload_en && rld_wr) begin
            active_q <= rld_wdata;
        end else if (upd_now) begin
            active_q <= stage_q;
        end
    end

    assign active = active_q;

    AST_DIRECT_LOAD: assert property (@(posedge clk) disable iff (rst)
        (!cfg.preload_en && rld_wr) |=> (active_q == $past(rld_wdata))); // R2

    AST_STAGED_HOLD: assert property (@(posedge clk) disable iff (rst)
        (cfg.preload_en && !upd_now) |=> $stable(active_q)); // R3

endmodule

// File: rtl/ucnt_core.sv
module ucnt_core
    import reload_upcounter_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  ucnt_cfg_t        cfg,
    input  logic             cnt_en,
    input  logic             tick,
    input  logic             sw_upd,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] count,
    output logic             upd_now,
    output ucnt_evt_t        evt
);

    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] count_d;
    logic             step;
    logic             wrap_now;
    logic             flag_now;
    ucnt_evt_t        evt_q;

    assign step     = cnt_en && tick && (limit != '0);
    assign wrap_now = step && !sw_upd && !cnt_wr &&
                      limit_hit(64'(count_q), 64'(limit));
    assign upd_now  = !cfg.upd_dis && (wrap_now || sw_upd);
    assign flag_now = !cfg.upd_dis && (wrap_now || (sw_upd && !cfg.req_src));

    always_comb begin
        count_d = count_q;
        if (sw_upd) begin
            count_d = '0;
        end else if (cnt_wr) begin
            count_d = cnt_wdata;
        end else if (wrap_now) begin
            count_d = '0;
        end else if (step) begin
            count_d = count_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
            evt_q   <= EVT_NONE;
        end else begin
            count_q     <= count_d;
            evt_q.upd   <= upd_now;
            evt_q.ovf   <= wrap_now;
            evt_q.flag  <= flag_now;
            evt_q.restart <= sw_upd;
        end
    end

    assign count = count_q;
    assign evt   = evt_q;

    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
        evt_q.ovf |-> (count_q == '0)); // R1

    AST_INHIBIT: assert property (@(posedge clk) disable iff (rst)
        (cfg.upd_dis && !sw_upd) |=> (!evt_q.upd && !evt_q.flag)); // R4

    AST_SW_CLEAR: assert property (@(posedge clk) disable iff (rst)
        sw_upd |=> (count_q == '0 && evt_q.restart)); // R5

    AST_SRC_SELECT: assert property (@(posedge clk) disable iff (rst)
        (sw_upd && cfg.req_src) |=> !evt_q.flag); // R6

    AST_ZERO_LIMIT: assert property (@(posedge clk) disable iff (rst)
        (limit == '0 && !sw_upd && !cnt_wr) |=> ($stable(count_q) && !evt_q.ovf)); // R9

    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
        (cnt_wr && !sw_upd) |=> (count_q == $past(cnt_wdata))); // R12

endmodule

// File: rtl/reload_upcounter.sv
module reload_upcounter
    import reload_upcounter_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             en_wr_i,
    input  logic             en_val_i,
    input  logic             preload_en_i,
    input  logic             upd_dis_i,
    input  logic             req_src_i,
    input  logic             one_shot_i,
    input  logic             sw_upd_i,
    input  logic             cnt_wr_i,
    input  logic [CNT_W-1:0] cnt_wdata_i,
    input  logic             rld_wr_i,
    input  logic [CNT_W-1:0] rld_wdata_i,
    output logic [CNT_W-1:0] count_o,
    output logic             update_o,
    output logic             ovf_o,
    output logic             flag_req_o,
    output logic             psc_restart_o,
    output logic             run_o,
    output logic [CNT_W-1:0] reload_active_o
);

    localparam logic [CNT_W-1:0] RELOAD_RST = {CNT_W{1'b1}};

    ucnt_cfg_t        cfg;
    ucnt_evt_t        evt;
    logic             upd_now;
    logic             cnt_en;
    logic [CNT_W-1:0] limit;

    assign cfg = '{preload_en: preload_en_i, upd_dis: upd_dis_i,
                   req_src: req_src_i, one_shot: one_shot_i};

    ucnt_enable u_enable (
        .clk     (clk),
        .rst     (rst),
        .en_wr   (en_wr_i),
        .en_val  (en_val_i),
        .cfg     (cfg),
        .upd_now (upd_now),
        .run     (run_o),
        .cnt_en  (cnt_en)
    );

    ucnt_reload #(
        .CNT_W      (CNT_W),
        .RELOAD_RST (RELOAD_RST)
    ) u_reload (
        .clk       (clk),
        .rst       (rst),
        .cfg       (cfg),
        .rld_wr    (rld_wr_i),
        .rld_wdata (rld_wdata_i),
        .upd_now   (upd_now),
        .active    (limit)
    );

    ucnt_core #(
        .CNT_W (CNT_W)
    ) u_core (
        .clk       (clk),
        .rst       (rst),
        .cfg       (cfg),
        .cnt_en    (cnt_en),
        .tick      (tick_i),
        .sw_upd    (sw_upd_i),
        .cnt_wr    (cnt_wr_i),
        .cnt_wdata (cnt_wdata_i),
        .limit     (limit),
        .count     (count_o),
        .upd_now   (upd_now),
        .evt       (evt)
    );

    assign update_o        = evt.upd;
    assign ovf_o           = evt.ovf;
    assign flag_req_o      = evt.flag;
    assign psc_restart_o   = evt.restart;
    assign reload_active_o = limit;

    AST_FLAG_NEEDS_UPDATE: assert property (@(posedge clk) disable iff (rst)
        flag_req_o |-> update_o); // R6

    AST_RESET_STATE: assert property (@(posedge clk)
        $past(rst) |-> (count_o == '0 && !run_o && !update_o && reload_active_o == RELOAD_RST)); // R10

endmodule

// File: tb/reload_upcounter_tb.sv
module reload_upcounter_tb;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         tick_i = 1'b0, en_wr_i = 1'b0, en_val_i = 1'b0;
    logic         preload_en_i = 1'b0, upd_dis_i = 1'b0, req_src_i = 1'b0, one_shot_i = 1'b0;
    logic         sw_upd_i = 1'b0, cnt_wr_i = 1'b0, rld_wr_i = 1'b0;
    logic [W-1:0] cnt_wdata_i = '0, rld_wdata_i = '0;
    logic [W-1:0] count_o, reload_active_o;
    logic         update_o, ovf_o, flag_req_o, psc_restart_o, run_o;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    reload_upcounter #(.CNT_W(W)) u_dut (
        .clk(clk), .rst(rst), .tick_i(tick_i), .en_wr_i(en_wr_i), .en_val_i(en_val_i),
        .preload_en_i(preload_en_i), .upd_dis_i(upd_dis_i), .req_src_i(req_src_i),
        .one_shot_i(one_shot_i), .sw_upd_i(sw_upd_i), .cnt_wr_i(cnt_wr_i),
        .cnt_wdata_i(cnt_wdata_i), .rld_wr_i(rld_wr_i), .rld_wdata_i(rld_wdata_i),
        .count_o(count_o), .update_o(update_o), .ovf_o(ovf_o), .flag_req_o(flag_req_o),
        .psc_restart_o(psc_restart_o), .run_o(run_o), .reload_active_o(reload_active_o)
    );

    // Vector: [17] tick, [16] expected ovf_o, [15:0] expected count, limit 3.
    localparam logic [17:0] VEC [12] = '{
        {1'b1, 1'b0, 16'd1}, {1'b1, 1'b0, 16'd2}, {1'b0, 1'b0, 16'd2},
        {1'b1, 1'b0, 16'd3}, {1'b1, 1'b1, 16'd0}, {1'b1, 1'b0, 16'd1},
        {1'b0, 1'b0, 16'd1}, {1'b1, 1'b0, 16'd2}, {1'b1, 1'b0, 16'd3},
        {1'b1, 1'b1, 16'd0}, {1'b0, 1'b0, 16'd0}, {1'b1, 1'b0, 16'd1}
    };

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Advance one clock edge; inputs change and outputs are sampled at negedge.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        tick_i = 0; en_wr_i = 0; sw_upd_i = 0; cnt_wr_i = 0; rld_wr_i = 0;
    endtask

    task automatic write_reload(input logic [W-1:0] v);
        rld_wr_i = 1; rld_wdata_i = v; step(); rld_wr_i = 0;
    endtask

    task automatic set_run(input logic v);
        en_wr_i = 1; en_val_i = v; step(); en_wr_i = 0;
    endtask

    task automatic write_count(input logic [W-1:0] v);
        cnt_wr_i = 1; cnt_wdata_i = v; step(); cnt_wr_i = 0;
    endtask

    task automatic do_reset();
        idle();
        preload_en_i = 0; upd_dis_i = 0; req_src_i = 0; one_shot_i = 0;
        rst = 1; step(); step(); rst = 0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R10 reset state
        check("R10", "count", count_o, 0);
        check("R10", "run", run_o, 0);
        check("R10", "reload", reload_active_o, 16'hFFFF);
        check("R10", "events", {update_o, ovf_o, flag_req_o, psc_restart_o}, 0);

        // R8 enable lag with tick held high
        tick_i = 1; en_wr_i = 1; en_val_i = 1; step(); en_wr_i = 0;
        step();
        check("R8", "count after first tick", count_o, 0);
        step();
        check("R8", "count after second tick", count_o, 1);
        tick_i = 0;

        // R1 table walk, limit 3, direct reload
        write_count(0);
        write_reload(3);
        for (int i = 0; i < 12; i++) begin
            tick_i = VEC[i][17];
            step();
            check("R1", "count", count_o, VEC[i][15:0]);
            check("R1", "ovf", ovf_o, VEC[i][16]);
        end
        tick_i = 0;

        // R2 direct reload
        write_reload(5);
        check("R2", "active reload", reload_active_o, 5);

        // R3 staged reload
        preload_en_i = 1;
        write_reload(7);
        check("R3", "active before update", reload_active_o, 5);
        sw_upd_i = 1; step(); sw_upd_i = 0;
        check("R3", "active after update", reload_active_o, 7);
        check("R5", "update pulse", update_o, 1);
        check("R5", "restart pulse", psc_restart_o, 1);

        // R4 inhibited overflow
        upd_dis_i = 1;
        write_count(7);
        tick_i = 1; step(); tick_i = 0;
        check("R4", "count wrapped", count_o, 0);
        check("R4", "ovf", ovf_o, 1);
        check("R4", "update", update_o, 0);
        check("R4", "flag", flag_req_o, 0);

        // R5 inhibited software update keeps active reload
        write_reload(9);
        write_count(4);
        sw_upd_i = 1; step(); sw_upd_i = 0;
        check("R5", "count cleared", count_o, 0);
        check("R5", "restart", psc_restart_o, 1);
        check("R5", "no update", update_o, 0);
        check("R5", "active kept", reload_active_o, 7);
        upd_dis_i = 0;

        // R6 request source select
        req_src_i = 1;
        sw_upd_i = 1; step(); sw_upd_i = 0;
        check("R6", "sw update", update_o, 1);
        check("R6", "sw flag", flag_req_o, 0);
        check("R6", "active loaded", reload_active_o, 9);
        write_count(9);
        tick_i = 1; step(); tick_i = 0;
        check("R6", "ovf update", update_o, 1);
        check("R6", "ovf flag", flag_req_o, 1);
        req_src_i = 0;

        // R11 overflow coinciding with software update
        write_count(9);
        tick_i = 1; sw_upd_i = 1; step(); sw_upd_i = 0; tick_i = 0;
        check("R11", "update", update_o, 1);
        check("R11", "count", count_o, 0);
        step();
        check("R11", "single pulse", update_o, 0);

        // R12 counter write beats increment
        cnt_wr_i = 1; cnt_wdata_i = 4; tick_i = 1; step(); cnt_wr_i = 0; tick_i = 0;
        check("R12", "count", count_o, 4);

        // R7 one-shot stop
        one_shot_i = 1;
        write_count(8);
        tick_i = 1; step();
        check("R7", "count at 9", count_o, 9);
        step();
        check("R7", "update", update_o, 1);
        check("R7", "run cleared", run_o, 0);
        step(); step();
        tick_i = 0;
        check("R7", "count held", count_o, 0);
        one_shot_i = 0;

        // R9 zero reload holds the counter
        preload_en_i = 0;
        set_run(1);
        write_count(2);
        write_reload(0);
        tick_i = 1; step(); step(); step(); tick_i = 0;
        check("R9", "count held", count_o, 2);
        check("R9", "no ovf", ovf_o, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule